// File: doc/BRIEF.md
# Coarse-Page Memory Permission Checker

This block decides whether one physical memory access may go ahead, using the leaf word of a memory tracking table that covers a 32 MiB region. The region is cut into equal coarse pages: eight pages of 4 MiB when the narrow (32-bit) mode is selected, sixteen pages of 2 MiB in the wide (64-bit) mode. Each page owns a 2-bit permission code inside the 32-bit leaf word. The code grants nothing, read plus execute, read plus write, or all three, so write or execute alone is never granted.

A request carries the physical address, the access kind, the current privilege, the MPRV bit, the MPP field, a flag marking fetches the checker makes to read its own table, the leaf word and the mode select. The request is taken on a valid/ready handshake. One cycle later a registered response (allow, fault and a fault cause) appears and is held until the consumer accepts it. Machine-privilege accesses and table fetches pass without a check. Data accesses made in machine mode with MPRV set and MPP naming a lower privilege are checked.

Top module: `coarse_page_guard`

## Requirements
- R1: After reset `rspValid` is 0 and `reqReady` is 1.
- R2: A request is accepted on a clock edge where `reqValid` and `reqReady` are both 1. Its response is visible with `rspValid` = 1 right after that same edge. `reqReady` is 1 whenever no response is held or the held one is being accepted (`rspReady` = 1).
- R3: While `rspValid` = 1 and `rspReady` = 0, the response (`rspValid`, `rspAllow`, `rspFault`, `rspCause`) does not change.
- R4: In narrow mode (`wideMode` = 0) the page index is address bits [24:22]. In wide mode it is bits [24:21]. Page p takes its code from leaf bits [2p+1:2p]. Address bits outside the index do not affect the result.
- R5: Access kinds are 0 = read, 1 = write, 2 = execute. Code 00 grants nothing, 01 grants read and execute, 10 grants read and write, 11 grants all three. An access that its code does not grant faults with cause 1 (denied). An access that is granted gives `rspAllow` = 1, `rspFault` = 0 and cause 0.
- R6: In narrow mode a leaf word with any of bits [31:16] set makes every checked access fault with cause 2 (reserved), whatever the code. In wide mode all 32 bits are page codes and no access faults with cause 2.
- R7: Access kind 3 is invalid. A checked access of kind 3 faults with cause 3, unless the cause-2 rule of R6 applies, which takes priority.
- R8: Privilege encoding is 0 = U, 1 = S, 3 = M. An access at privilege M with MPRV = 0 is allowed whatever the leaf word.
- R9: At privilege M with MPRV = 1, a data access (read or write) is checked at the privilege held in MPP. When MPP is M, the access is allowed. An execute access is always allowed in this case.
- R10: A request with `reqWalk` = 1 (a table fetch made by the checker) is allowed whatever the leaf word, kind or privilege.
- R11: Every valid response has exactly one of `rspAllow` and `rspFault` set. `rspFault` = 1 comes with a non-zero cause, and `rspAllow` = 1 with cause 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can take a request |
| reqAddr | input | ADDR_W (34) | Physical address |
| reqKind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 invalid |
| reqPriv | input | 2 | Current privilege: 0 U, 1 S, 3 M |
| reqMprv | input | 1 | Modify-privilege bit |
| reqMpp | input | 2 | Previous privilege field |
| reqWalk | input | 1 | Access is the checker's own table fetch |
| leafInfo | input | INFO_W (32) | Leaf permission word |
| wideMode | input | 1 | 1 = sixteen 2 MiB pages, 0 = eight 4 MiB pages |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Consumer takes the response |
| rspAllow | output | 1 | Access permitted |
| rspFault | output | 1 | Access refused |
| rspCause | output | 2 | 0 none, 1 denied, 2 reserved bits set, 3 invalid kind |

## Verification
The assertions check the handshake on every cycle: each accepted request gives a response on the next edge, a stalled response keeps its valid bit and payload, and a valid response has exactly one of allow and fault with a matching cause. They also check that table fetches and machine-mode accesses without MPRV always come back allowed. The scenarios are the only place where page selection by address bits is shown, in both modes and on every page. They also cover the code-by-kind grant matrix, the priority of the reserved-bit fault over the invalid-kind fault, the MPRV/MPP redirection for data versus execute, and the insensitivity to address bits outside the index.

// File: rtl/coarse_guard_pkg.sv
package coarse_guard_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_EXEC  = 2'd2,
    KIND_BAD   = 2'd3
  } accKind_e;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_DENIED = 2'd1,
    CAUSE_RSVD   = 2'd2,
    CAUSE_KIND   = 2'd3
  } cause_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // request accepted this edge
    logic retire;    // held response consumed this edge
  } ctlStrobes_t;

endpackage

// File: rtl/cpg_control.sv
module cpg_control
  import coarse_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  output logic        rspValid,
  input  logic        rspReady,
  output ctlStrobes_t strobes
);

  logic validQ;

  assign rspValid = validQ;
  assign reqReady = !validQ || rspReady;

  always_comb begin
    strobes.capture = reqValid && reqReady;
    strobes.retire  = validQ && rspReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (strobes.capture) begin
      validQ <= 1'b1;
    end else if (strobes.retire) begin
      validQ <= 1'b0;
    end
  end

  // R2: an accepted request shows up as a response on the next edge
  a_r2_accept_gives_rsp: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);

  // R3: a stalled response stays valid
  a_r3_hold_valid: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> rspValid);

  // R3: a stalled response blocks new requests
  a_r3_no_accept_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |-> !reqReady);

endmodule

// File: rtl/cpg_datapath.sv
module cpg_datapath
  import coarse_guard_pkg::*;
#(
  parameter int ADDR_W         = 34,
  parameter int INFO_W         = 32,
  parameter int REGION_LSB     = 25,
  parameter int NARROW_PAGE_LSB = 22,
  parameter int WIDE_PAGE_LSB  = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqKind,
  input  logic [1:0]        reqPriv,
  input  logic              reqMprv,
  input  logic [1:0]        reqMpp,
  input  logic              reqWalk,
  input  logic [INFO_W-1:0] leafInfo,
  input  logic              wideMode,
  output logic              rspAllow,
  output logic              rspFault,
  output logic [1:0]        rspCause
);

  localparam int NarrowIdxW  = REGION_LSB - NARROW_PAGE_LSB;
  localparam int WideIdxW    = REGION_LSB - WIDE_PAGE_LSB;
  localparam int NarrowPages = 1 << NarrowIdxW;
  localparam int WidePages   = 1 << WideIdxW;
  localparam int NarrowUsed  = 2 * NarrowPages;
  localparam int WideUsed    = 2 * WidePages;

  // ---------------- privilege resolution ----------------
  accKind_e kind;
  priv_e    curPriv;
  priv_e    effPriv;
  logic     dataAccess;
  logic     mprvRedirect;
  logic     exempt;

  assign kind    = accKind_e'(reqKind);
  assign curPriv = priv_e'(reqPriv);

  always_comb begin
    dataAccess   = (kind != KIND_EXEC);
    mprvRedirect = (curPriv == PRIV_M) && reqMprv && dataAccess;
    effPriv      = mprvRedirect ? priv_e'(reqMpp) : curPriv;
    exempt       = reqWalk || (effPriv == PRIV_M);
  end

  // ---------------- page index ----------------
  logic [NarrowIdxW-1:0] narrowIdx;
  logic [WideIdxW-1:0]   wideIdx;
  logic [WideIdxW-1:0]   pageIdx;

  assign narrowIdx = reqAddr[REGION_LSB-1:NARROW_PAGE_LSB];
  assign wideIdx   = reqAddr[REGION_LSB-1:WIDE_PAGE_LSB];
  assign pageIdx   = wideMode ? wideIdx : WideIdxW'(narrowIdx);

  // ---------------- per-page grant decode ----------------
  logic [WidePages-1:0] grantRd;
  logic [WidePages-1:0] grantWr;
  logic [WidePages-1:0] grantEx;

  for (genvar p = 0; p < WidePages; p++) begin : g_page
    logic [1:0] code;
    assign code       = leafInfo[2*p +: 2];
    assign grantRd[p] = |code;        // any non-zero code grants read
    assign grantWr[p] = code[1];      // 10 and 11
    assign grantEx[p] = code[0];      // 01 and 11
  end

  // ---------------- reserved bits ----------------
  logic narrowRsvd;
  logic wideRsvd;
  logic rsvdSet;

  if (INFO_W > NarrowUsed) begin : g_narrow_rsvd
    assign narrowRsvd = |leafInfo[INFO_W-1:NarrowUsed];
  end else begin : g_narrow_none
    assign narrowRsvd = 1'b0;
  end

  if (INFO_W > WideUsed) begin : g_wide_rsvd
    assign wideRsvd = |leafInfo[INFO_W-1:WideUsed];
  end else begin : g_wide_none
    assign wideRsvd = 1'b0;
  end

  assign rsvdSet = wideMode ? wideRsvd : narrowRsvd;

  // ---------------- verdict ----------------
  logic   permitted;
  cause_e nextCause;

  always_comb begin
    unique case (kind)
      KIND_READ:  permitted = grantRd[pageIdx];
      KIND_WRITE: permitted = grantWr[pageIdx];
      KIND_EXEC:  permitted = grantEx[pageIdx];
      default:    permitted = 1'b0;
    endcase
  end

  always_comb begin
    if (exempt)                nextCause = CAUSE_NONE;
    else if (rsvdSet)          nextCause = CAUSE_RSVD;
    else if (kind == KIND_BAD) nextCause = CAUSE_KIND;
    else if (!permitted)       nextCause = CAUSE_DENIED;
    else                       nextCause = CAUSE_NONE;
  end

  // ---------------- response registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspAllow <= 1'b0;
      rspFault <= 1'b0;
      rspCause <= CAUSE_NONE;
    end else if (strobes.capture) begin
      rspAllow <= (nextCause == CAUSE_NONE);
      rspFault <= (nextCause != CAUSE_NONE);
      rspCause <= nextCause;
    end else if (strobes.retire) begin
      rspAllow <= 1'b0;
      rspFault <= 1'b0;
      rspCause <= CAUSE_NONE;
    end
  end

  // R3: payload untouched when control issues no strobe
  a_r3_payload_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.capture && !strobes.retire) |=>
      ($stable(rspAllow) && $stable(rspFault) && $stable(rspCause)));

  // R10: table fetches are always allowed
  a_r10_walk_allowed: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && reqWalk) |=> rspAllow);

  // R8: machine mode without MPRV is always allowed
  a_r8_machine_allowed: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && reqPriv == 2'd3 && !reqMprv) |=> rspAllow);

  // R9: execute in machine mode is never redirected
  a_r9_exec_exempt: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && reqPriv == 2'd3 && reqKind == 2'd2) |=> rspAllow);

  // R11: a fault always carries a cause
  a_r11_fault_cause: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (rspCause != 2'd0));

endmodule

// File: rtl/coarse_page_guard.sv
module coarse_page_guard
  import coarse_guard_pkg::*;
#(
  parameter int ADDR_W = 34,
  parameter int INFO_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqKind,
  input  logic [1:0]        reqPriv,
  input  logic              reqMprv,
  input  logic [1:0]        reqMpp,
  input  logic              reqWalk,
  input  logic [INFO_W-1:0] leafInfo,
  input  logic              wideMode,
  output logic              rspValid,
  input  logic              rspReady,
  output logic              rspAllow,
  output logic              rspFault,
  output logic [1:0]        rspCause
);

  ctlStrobes_t strobes;

  cpg_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .rspReady (rspReady),
    .strobes  (strobes)
  );

  cpg_datapath #(
    .ADDR_W (ADDR_W),
    .INFO_W (INFO_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqAddr  (reqAddr),
    .reqKind  (reqKind),
    .reqPriv  (reqPriv),
    .reqMprv  (reqMprv),
    .reqMpp   (reqMpp),
    .reqWalk  (reqWalk),
    .leafInfo (leafInfo),
    .wideMode (wideMode),
    .rspAllow (rspAllow),
    .rspFault (rspFault),
    .rspCause (rspCause)
  );

  // R11: a valid response is either allow or fault, never both
  a_r11_one_verdict: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspAllow ^ rspFault));

  // R11: no verdict is shown without a valid response
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspAllow && !rspFault));

endmodule

// File: tb/coarse_page_guard_tb_top.sv
module coarse_page_guard_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [33:0] reqAddr = '0;
  logic [1:0]  reqKind = '0;
  logic [1:0]  reqPriv = '0;
  logic        reqMprv = 1'b0;
  logic [1:0]  reqMpp = '0;
  logic        reqWalk = 1'b0;
  logic [31:0] leafInfo = '0;
  logic        wideMode = 1'b0;
  logic        rspValid;
  logic        rspReady = 1'b0;
  logic        rspAllow;
  logic        rspFault;
  logic [1:0]  rspCause;

  always #5 clk = ~clk;

  coarse_page_guard dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqKind(reqKind), .reqPriv(reqPriv),
    .reqMprv(reqMprv), .reqMpp(reqMpp), .reqWalk(reqWalk),
    .leafInfo(leafInfo), .wideMode(wideMode),
    .rspValid(rspValid), .rspReady(rspReady),
    .rspAllow(rspAllow), .rspFault(rspFault), .rspCause(rspCause)
  );

  typedef struct {
    logic [1:0] cause;
    int         acceptCyc;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int  nCompared = 0;
  int  nMismatched = 0;
  int  cyc = 0;
  bit  backpressure = 1'b0;
  bit  finished = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  always @(posedge clk) cyc <= cyc + 1;

  // Consumer readiness, changed on the falling edge
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rspReady <= backpressure ? lfsr[0] : 1'b1;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nCompared++;
    if (!ok) begin
      nMismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Model written from the requirements
  function automatic logic [1:0] modelCause(
    input logic [33:0] a, input logic [1:0] k, input logic [1:0] pv,
    input logic m, input logic [1:0] mpp, input logic w,
    input logic [31:0] info, input logic wide);
    logic [1:0] eff;
    logic [3:0] idx;
    logic [1:0] code;
    logic ok;
    eff = (pv == 2'd3 && m && k != 2'd2) ? mpp : pv;
    if (w || eff == 2'd3) return 2'd0;
    if (!wide && info[31:16] != 16'h0) return 2'd2;
    if (k == 2'd3) return 2'd3;
    idx  = wide ? a[24:21] : {1'b0, a[24:22]};
    code = info[idx*2 +: 2];
    case (k)
      2'd0:    ok = (code != 2'b00);
      2'd1:    ok = code[1];
      default: ok = code[0];
    endcase
    return ok ? 2'd0 : 2'd1;
  endfunction

  // Driver: pushes the expected item when the request is taken
  task automatic send(input logic [33:0] a, input logic [1:0] k,
                      input logic [1:0] pv, input logic m, input logic [1:0] mpp,
                      input logic w, input logic [31:0] info, input logic wide,
                      input string tag);
    expItem_t it;
    @(negedge clk);
    reqAddr = a; reqKind = k; reqPriv = pv; reqMprv = m; reqMpp = mpp;
    reqWalk = w; leafInfo = info; wideMode = wide; reqValid = 1'b1;
    forever begin
      #1;
      if (reqReady) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    it.cause = modelCause(a, k, pv, m, mpp, w, info, wide);
    it.acceptCyc = cyc;
    it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // Monitor: compares responses as they are consumed
  initial begin
    bit isNew = 1'b1;
    bit haveSnap = 1'b0;
    logic [4:0] snap = '0;
    forever begin
      @(negedge clk);
      #2;
      if (!rstN) continue;
      if (haveSnap) begin
        check({rspValid, rspAllow, rspFault, rspCause} == snap, "R3",
              "stalled response changed", {rspValid, rspAllow, rspFault, rspCause}, snap);
        haveSnap = 1'b0;
      end
      if (rspValid && isNew) begin
        isNew = 1'b0;
        if (expQ.size() == 0) begin
          check(1'b0, "R2", "response without request", 1, 0);
        end else begin
          check(cyc == expQ[0].acceptCyc, "R2", "response latency", cyc, expQ[0].acceptCyc);
        end
      end
      if (rspValid && rspReady && expQ.size() != 0) begin
        expItem_t e;
        e = expQ.pop_front();
        check(rspCause == e.cause && rspAllow == (e.cause == 2'd0) &&
              rspFault == (e.cause != 2'd0),
              e.tag, "verdict {allow,fault,cause}",
              {rspAllow, rspFault, rspCause},
              {(e.cause == 2'd0), (e.cause != 2'd0), e.cause});
        isNew = 1'b1;
      end else if (rspValid && !rspReady) begin
        snap = {rspValid, rspAllow, rspFault, rspCause};
        haveSnap = 1'b1;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nMismatched++;
      nCompared++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #2;
    // R1 reset state
    check(rspValid == 1'b0, "R1", "rspValid after reset", rspValid, 0);
    check(reqReady == 1'b1, "R1", "reqReady after reset", reqReady, 1);

    // R4/R5 narrow mode sweep: codes 00,01,10,11 repeated; upper address bits set
    for (int p = 0; p < 8; p++)
      for (int k = 0; k < 3; k++)
        send((34'h1 << 30) | (34'(p) << 22) | 34'h3_1234, 2'(k), 2'd1, 1'b0, 2'd0,
             1'b0, 32'h0000_E4E4, 1'b0, "R4_R5_narrow");

    backpressure = 1'b1;
    // R4/R5 wide mode sweep, under backpressure (R3)
    for (int p = 0; p < 16; p++)
      for (int k = 0; k < 3; k++)
        send((34'h2 << 32) | (34'(p) << 21) | 34'h1_5A5A, 2'(k), 2'd0, 1'b0, 2'd0,
             1'b0, 32'h1B1B_E4E4, 1'b1, "R4_R5_wide");

    // R6 reserved bits
    send(34'h0, 2'd0, 2'd1, 1'b0, 2'd0, 1'b0, 32'h0001_FFFF, 1'b0, "R6_narrow_rsvd");
    send(34'h0, 2'd0, 2'd1, 1'b0, 2'd0, 1'b0, 32'h8000_0003, 1'b0, "R6_narrow_rsvd_top");
    send(34'h0, 2'd0, 2'd1, 1'b0, 2'd0, 1'b0, 32'h0001_FFFF, 1'b1, "R6_wide_no_rsvd");
    send(34'h1E0_0000, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 32'h8000_0000, 1'b1, "R6_wide_top_page");

    // R7 invalid kind, and priority of R6
    send(34'h0, 2'd3, 2'd1, 1'b0, 2'd0, 1'b0, 32'h0000_FFFF, 1'b0, "R7_bad_kind");
    send(34'h0, 2'd3, 2'd0, 1'b0, 2'd0, 1'b0, 32'h0001_0000, 1'b0, "R7_rsvd_first");

    // R8 machine mode
    send(34'h0, 2'd1, 2'd3, 1'b0, 2'd0, 1'b0, 32'h0000_0000, 1'b0, "R8_m_write");
    send(34'h0, 2'd2, 2'd3, 1'b0, 2'd0, 1'b0, 32'hFFFF_0000, 1'b0, "R8_m_rsvd");

    // R9 MPRV redirection
    send(34'h0, 2'd0, 2'd3, 1'b1, 2'd1, 1'b0, 32'h0000_0000, 1'b0, "R9_mprv_s_read");
    send(34'h0, 2'd1, 2'd3, 1'b1, 2'd0, 1'b0, 32'h0000_0001, 1'b0, "R9_mprv_u_write");
    send(34'h0, 2'd1, 2'd3, 1'b1, 2'd0, 1'b0, 32'h0000_0002, 1'b0, "R9_mprv_u_write_ok");
    send(34'h0, 2'd2, 2'd3, 1'b1, 2'd1, 1'b0, 32'h0000_0000, 1'b0, "R9_mprv_exec");
    send(34'h0, 2'd1, 2'd3, 1'b1, 2'd3, 1'b0, 32'h0000_0000, 1'b0, "R9_mpp_m");
    send(34'h0, 2'd0, 2'd1, 1'b1, 2'd3, 1'b0, 32'h0000_0000, 1'b0, "R9_mprv_not_m");

    // R10 table fetch
    send(34'h0, 2'd1, 2'd0, 1'b0, 2'd0, 1'b1, 32'h0000_0000, 1'b0, "R10_walk");
    send(34'h0, 2'd3, 2'd1, 1'b0, 2'd0, 1'b1, 32'hFFFF_0000, 1'b0, "R10_walk_rsvd");
    send(34'h0, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 32'h0000_0000, 1'b0, "R11_denied");

    backpressure = 1'b0;
    while (expQ.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

endmodule